// File: doc/BRIEF.md
# Cache Capacity Block-Mask Allocator

This block holds the cache capacity allocation masks of a shared cache. Each resource-control ID owns one mask per access type (data and code), and every mask bit grants that ID the use of one capacity block. The replacement logic that consumes the masks sits outside this block.

Software works through a small 64-bit register window. It first places a mask in a staging area, which spans one or more 64-bit slots when there are more than 64 capacity blocks. It then writes an allocation command word. The command can store the staged mask for an ID and access type, copy an ID's mask back into the staging area, or flush an ID's mask to zero. Every command completes in one clock. The result code is left in the command register, so busy always reads 0. A read-only capabilities word reports the version, the block count and whether flush is available. After reset, ID 0 owns every block for each access type, and every other ID owns none.

Top module: `capacity_mask_alloc`

## Requirements
- R1: Registers are 64 bits wide at byte offsets on 8-byte boundaries. Reads are combinational from the current address. Offset 0 is the capabilities word: bits 3:0 minor version, bits 7:4 major version, bits 23:8 block count, bit 24 flush available. With the default parameters it reads 0x0000_0000_0100_5012.
- R2: A write to offset 24 is a command: op in bits 4:0, access type in bits 7:5 (0 data, 1 code), ID in bits 19:8. Afterwards offset 24 reads back op, access type and ID in the same positions, a status in bits 38:32 and a busy bit 39 that is always 0.
- R3: Op 1 with valid fields stores the staged mask (its low block-count bits) for that ID and access type, with status 1. Masks of other entries are not touched.
- R4: Op 2 with valid fields copies the selected mask into the staging slots, zero above the block count, with status 1.
- R5: Op 3 with valid fields clears the selected mask, with status 1.
- R6: Checks are applied in order. An ID at or above the ID count gives status 3. Otherwise an access type other than 0 or 1 gives status 4. Otherwise an op other than 1, 2 or 3 gives status 2. A failed command changes no mask and no staging slot.
- R7: Op 1 with any staged bit set at or above the block count in the last slot gives status 5 and leaves the mask unchanged.
- R8: Staging slot k lives at offset 32+8k. Writes to slots at or beyond ceil(count/64) are ignored, and reads there return 0. Unaligned offsets and offsets 8 and 16 also read 0.
- R9: After reset, the command register and the staging slots read 0. ID 0 holds all ones in the low block-count bits for both access types, and every other ID holds zero.
- R10: Writes to the capabilities offset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte offset of the access |
| regWrData | input | 64 | Write data |
| regRdData | output | 64 | Read data for regAddr, combinational |

## Verification
A corrupted mask entry stays invisible until software fetches it with op 2. From that point the wrong bits show in the staging slots one clock after the command. A wrong status or decode appears in the command register in the cycle after the write, so every command is read back at once. Staging corruption shows directly on slot reads. Through a later commit it also reaches the stored masks, which a final sweep over all entries exposes.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

  typedef enum logic [6:0] {
    ST_NONE     = 7'd0,
    ST_OK       = 7'd1,
    ST_BAD_OP   = 7'd2,
    ST_BAD_ID   = 7'd3,
    ST_BAD_AT   = 7'd4,
    ST_BAD_MASK = 7'd5
  } status_e;

  localparam logic [4:0] OP_COMMIT = 5'd1;
  localparam logic [4:0] OP_FETCH  = 5'd2;
  localparam logic [4:0] OP_FLUSH  = 5'd3;

  localparam int OFF_CAPS  = 0;
  localparam int OFF_ALLOC = 24;
  localparam int OFF_MASK  = 32;

  // strobes from control to datapath
  typedef struct packed {
    logic        ctlLoad;
    logic        commit;
    logic        fetch;
    logic        flush;
    logic [15:0] entryIdx;
    status_e     status;
    logic [4:0]  op;
    logic [2:0]  at;
    logic [11:0] id;
  } cmd_t;

endpackage

// File: rtl/cbm_ctrl.sv
module cbm_ctrl
  import cbm_pkg::*;
#(
  parameter int NUM_IDS    = 8,
  parameter int NUM_BLOCKS = 80,
  parameter bit HAS_DATA   = 1'b1,
  parameter bit HAS_CODE   = 1'b1,
  parameter bit HAS_FLUSH  = 1'b1,
  parameter int ADDR_W     = 12,
  parameter int SLOTS      = 2
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [19:0]       cmdWord,
  input  logic              tailDirty,
  output cmd_t              cmd,
  output logic              slotWe,
  output logic [7:0]        slotSel
);

  localparam int NUM_AT   = int'(HAS_DATA) + int'(HAS_CODE);
  localparam int AT_SLOTS = (NUM_AT > 0) ? NUM_AT : 1;
  localparam bit AT_ON    = (NUM_AT > 0);
  localparam bit ALLOC_ON = (NUM_BLOCKS > 0);

  logic [4:0]  op;
  logic [2:0]  at;
  logic [11:0] id;
  logic        idOk;
  logic        atOk;
  logic        atSel;
  logic        isAlloc;
  logic [31:0] slotOff;
  status_e     st;

  always_comb begin
    op      = cmdWord[4:0];
    id      = cmdWord[19:8];
    at      = AT_ON ? cmdWord[7:5] : 3'd0;
    idOk    = (32'(id) < NUM_IDS);
    atOk    = !AT_ON || ((at == 3'd0) && HAS_DATA) || ((at == 3'd1) && HAS_CODE);
    atSel   = (NUM_AT == 2) ? at[0] : 1'b0;
    isAlloc = regWrEn && (32'(regAddr) == OFF_ALLOC) && ALLOC_ON;

    // fixed check order: ID, access type, op
    if (!idOk)                          st = ST_BAD_ID;
    else if (!atOk)                     st = ST_BAD_AT;
    else if (op == OP_COMMIT)           st = tailDirty ? ST_BAD_MASK : ST_OK;
    else if (op == OP_FETCH)            st = ST_OK;
    else if (op == OP_FLUSH && HAS_FLUSH) st = ST_OK;
    else                                st = ST_BAD_OP;

    cmd          = '0;
    cmd.ctlLoad  = isAlloc;
    cmd.commit   = isAlloc && (st == ST_OK) && (op == OP_COMMIT);
    cmd.fetch    = isAlloc && (st == ST_OK) && (op == OP_FETCH);
    cmd.flush    = isAlloc && (st == ST_OK) && (op == OP_FLUSH);
    cmd.entryIdx = 16'(32'(id) * AT_SLOTS + 32'(atSel));
    cmd.status   = st;
    cmd.op       = op;
    cmd.at       = at;
    cmd.id       = id;

    slotOff = 32'(regAddr) - OFF_MASK;
    slotWe  = regWrEn && (32'(regAddr) >= OFF_MASK) && (regAddr[2:0] == 3'd0)
              && ((slotOff >> 3) < SLOTS);
    slotSel = 8'(slotOff >> 3);
  end

endmodule

// File: rtl/cbm_datapath.sv
module cbm_datapath
  import cbm_pkg::*;
#(
  parameter int NUM_IDS    = 8,
  parameter int NUM_BLOCKS = 80,
  parameter int AT_SLOTS   = 2,
  parameter bit HAS_FLUSH  = 1'b1,
  parameter int VER_MAJOR  = 1,
  parameter int VER_MINOR  = 2,
  parameter int ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmd_t              cmd,
  input  logic              slotWe,
  input  logic [7:0]        slotSel,
  input  logic [63:0]       regWrData,
  input  logic [ADDR_W-1:0] regAddr,
  output logic              tailDirty,
  output logic [63:0]       regRdData
);

  localparam int SLOTS_REAL  = (NUM_BLOCKS + 63) / 64;
  localparam int SLOTS_ALLOC = (SLOTS_REAL > 0) ? SLOTS_REAL : 1;
  localparam int FLAT_W      = SLOTS_ALLOC * 64;
  localparam int MASK_W      = (NUM_BLOCKS > 0) ? NUM_BLOCKS : 1;
  localparam int TAIL_BITS   = NUM_BLOCKS % 64;
  localparam int NUM_ENTRIES = NUM_IDS * AT_SLOTS;
  localparam int IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam logic [63:0] CAPS_WORD =
    {39'd0, HAS_FLUSH, 16'(NUM_BLOCKS), 4'(VER_MAJOR), 4'(VER_MINOR)};

  logic [63:0]       stage   [SLOTS_ALLOC];
  logic [MASK_W-1:0] maskMem [NUM_ENTRIES];
  logic [63:0]       ctlReg;
  logic [FLAT_W-1:0] stageFlat;
  logic [FLAT_W-1:0] fetchFlat;
  logic [IDX_W-1:0]  idx;
  logic              unusedIdx;

  assign idx       = cmd.entryIdx[IDX_W-1:0];
  assign unusedIdx = ^cmd.entryIdx;

  always_comb begin
    for (int s = 0; s < SLOTS_ALLOC; s++) stageFlat[s*64 +: 64] = stage[s];
    fetchFlat = FLAT_W'(maskMem[idx]);
  end

  generate
    if (TAIL_BITS != 0) begin : g_tail
      localparam logic [63:0] KEEP = (64'd1 << TAIL_BITS) - 64'd1;
      assign tailDirty = |(stage[SLOTS_ALLOC-1] & ~KEEP);
    end else begin : g_notail
      assign tailDirty = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SLOTS_ALLOC; s++) stage[s] <= '0;
      for (int e = 0; e < NUM_ENTRIES; e++) maskMem[e] <= (e < AT_SLOTS) ? '1 : '0;
      ctlReg <= '0;
    end else begin
      if (slotWe) stage[slotSel] <= regWrData;
      if (cmd.fetch)
        for (int s = 0; s < SLOTS_ALLOC; s++) stage[s] <= fetchFlat[s*64 +: 64];
      if (cmd.commit) maskMem[idx] <= stageFlat[MASK_W-1:0];
      if (cmd.flush)  maskMem[idx] <= '0;
      if (cmd.ctlLoad)
        ctlReg <= {24'd0, 1'b0, cmd.status, 12'd0, cmd.id, cmd.at, cmd.op};
    end
  end

  logic [31:0] rdOff;
  logic [31:0] rdSlot;

  always_comb begin
    rdOff     = 32'(regAddr);
    rdSlot    = (rdOff - OFF_MASK) >> 3;
    regRdData = '0;
    if (rdOff == OFF_CAPS)
      regRdData = CAPS_WORD;
    else if (rdOff == OFF_ALLOC)
      regRdData = ctlReg;
    else if (rdOff >= OFF_MASK && rdOff[2:0] == 3'd0 && rdSlot < SLOTS_REAL)
      regRdData = stage[rdSlot[7:0]];
  end

endmodule

// File: rtl/capacity_mask_alloc.sv
module capacity_mask_alloc
  import cbm_pkg::*;
#(
  parameter int NUM_IDS    = 8,
  parameter int NUM_BLOCKS = 80,
  parameter bit HAS_DATA   = 1'b1,
  parameter bit HAS_CODE   = 1'b1,
  parameter bit HAS_FLUSH  = 1'b1,
  parameter int VER_MAJOR  = 1,
  parameter int VER_MINOR  = 2,
  parameter int ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [63:0]       regWrData,
  output logic [63:0]       regRdData
);

  localparam int NUM_AT   = int'(HAS_DATA) + int'(HAS_CODE);
  localparam int AT_SLOTS = (NUM_AT > 0) ? NUM_AT : 1;
  localparam int SLOTS    = (NUM_BLOCKS + 63) / 64;

  cmd_t       cmd;
  logic       slotWe;
  logic [7:0] slotSel;
  logic       tailDirty;

  cbm_ctrl #(
    .NUM_IDS(NUM_IDS), .NUM_BLOCKS(NUM_BLOCKS), .HAS_DATA(HAS_DATA),
    .HAS_CODE(HAS_CODE), .HAS_FLUSH(HAS_FLUSH), .ADDR_W(ADDR_W), .SLOTS(SLOTS)
  ) u_ctrl (
    .regWrEn(regWrEn), .regAddr(regAddr), .cmdWord(regWrData[19:0]),
    .tailDirty(tailDirty), .cmd(cmd), .slotWe(slotWe), .slotSel(slotSel)
  );

  cbm_datapath #(
    .NUM_IDS(NUM_IDS), .NUM_BLOCKS(NUM_BLOCKS), .AT_SLOTS(AT_SLOTS),
    .HAS_FLUSH(HAS_FLUSH), .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR),
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .slotWe(slotWe), .slotSel(slotSel),
    .regWrData(regWrData), .regAddr(regAddr), .tailDirty(tailDirty),
    .regRdData(regRdData)
  );

endmodule

// File: rtl/capacity_mask_alloc_chk.sv
module capacity_mask_alloc_chk #(
  parameter int NUM_IDS    = 8,
  parameter int NUM_BLOCKS = 80,
  parameter bit HAS_FLUSH  = 1'b1,
  parameter int VER_MAJOR  = 1,
  parameter int VER_MINOR  = 2,
  parameter int ADDR_W     = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [63:0]       regWrData,
  input logic [63:0]       regRdData,
  input logic              tailDirty
);

  localparam int SLOTS = (NUM_BLOCKS + 63) / 64;
  localparam logic [63:0] CAPS_EXP =
    {39'd0, HAS_FLUSH, 16'(NUM_BLOCKS), 4'(VER_MAJOR), 4'(VER_MINOR)};

  logic onCtl;
  logic oobSlot;
  logic cmdWr;
  assign onCtl   = (32'(regAddr) == 24);
  assign oobSlot = (32'(regAddr) >= 32 + 8 * SLOTS);
  assign cmdWr   = regWrEn && onCtl;

  // R1: capabilities word
  a_r1_caps_word: assert property (@(posedge clk) disable iff (!rstN)
    (32'(regAddr) == 0) |-> (regRdData == CAPS_EXP));

  // R2: busy never reads set
  a_r2_busy_low: assert property (@(posedge clk) disable iff (!rstN)
    onCtl |-> !regRdData[39]);

  // R8: slots beyond range read zero
  a_r8_oob_zero: assert property (@(posedge clk) disable iff (!rstN)
    oobSlot |-> (regRdData == 64'd0));

  // R6: out-of-range ID reported first
  a_r6_bad_id: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && (32'(regWrData[19:8]) >= NUM_IDS))
      |=> (!onCtl || regRdData[38:32] == 7'd3));

  // R7: dirty tail rejects a commit
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && tailDirty && regWrData[4:0] == 5'd1 && regWrData[7:6] == 2'd0
     && (32'(regWrData[19:8]) < NUM_IDS))
      |=> (!onCtl || regRdData[38:32] == 7'd5));

endmodule

bind capacity_mask_alloc capacity_mask_alloc_chk #(
  .NUM_IDS(NUM_IDS), .NUM_BLOCKS(NUM_BLOCKS), .HAS_FLUSH(HAS_FLUSH),
  .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .regRdData(regRdData), .tailDirty(tailDirty)
);

// File: tb/sim_capacity_mask_alloc.sv
module sim_capacity_mask_alloc;

  localparam int CLK_PERIOD = 10;
  localparam int NIDS = 8;
  localparam int NENT = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [63:0] regWrData = '0;
  logic [63:0] regRdData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [79:0] mdl [NENT];
  logic [63:0] stg [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  capacity_mask_alloc u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [63:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [63:0] d);
    regWrEn = 1'b0; regAddr = a;
    #1 d = regRdData;
  endtask

  // expected status and model update for one command
  function automatic logic [6:0] model_cmd(int op, int at, int id);
    logic [127:0] flat;
    int e;
    if (id >= NIDS) return 7'd3;
    if (at > 1) return 7'd4;
    e = id * 2 + at;
    if (op == 1) begin
      if (stg[1][63:16] != 0) return 7'd5;
      mdl[e] = {stg[1][15:0], stg[0]};
      return 7'd1;
    end
    if (op == 2) begin
      flat = {48'd0, mdl[e]};
      stg[0] = flat[63:0];
      stg[1] = flat[127:64];
      return 7'd1;
    end
    if (op == 3) begin
      mdl[e] = '0;
      return 7'd1;
    end
    return 7'd2;
  endfunction

  task automatic do_cmd(string req, int op, int at, int id);
    logic [63:0] w, r, exp;
    logic [6:0] st;
    w = 64'(op) | (64'(at) << 5) | (64'(id) << 8);
    st = model_cmd(op, at, id);
    wr(12'd24, w);
    rd(12'd24, r);
    exp = w | (64'(st) << 32);
    chk(req, r, exp);
  endtask

  task automatic chk_stage(string req);
    logic [63:0] r;
    rd(12'd32, r); chk(req, r, stg[0]);
    rd(12'd40, r); chk(req, r, stg[1]);
  endtask

  task automatic wr_slot(int s, logic [63:0] d);
    wr(12'(32 + 8 * s), d);
    if (s < 2) stg[s] = d;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [63:0] r;
    void'($urandom(32'd7151));
    for (int e = 0; e < NENT; e++) mdl[e] = (e < 2) ? '1 : '0;
    stg[0] = '0; stg[1] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R9 reset state, R1 capabilities
    rd(12'd0, r);  chk("R1 caps", r, 64'h0000_0000_0100_5012);
    rd(12'd24, r); chk("R9 ctl reset", r, 64'd0);
    chk_stage("R9 staging reset");
    do_cmd("R9 fetch id0 data", 2, 0, 0);
    chk_stage("R9 id0 data all ones");
    do_cmd("R9 fetch id0 code", 2, 1, 0);
    chk_stage("R9 id0 code all ones");
    do_cmd("R9 fetch id3 code", 2, 1, 3);
    chk_stage("R9 id3 empty");

    // R3 commit to one entry only
    wr_slot(0, 64'hA5A5_0F0F_1234_5678);
    wr_slot(1, 64'h0000_0000_0000_BEEF);
    do_cmd("R3 commit id5 code", 1, 1, 5);
    do_cmd("R4 fetch id5 data", 2, 0, 5);
    chk_stage("R3 other access type untouched");
    do_cmd("R4 fetch id5 code", 2, 1, 5);
    chk_stage("R3 R4 committed mask back");

    // R7 dirty tail
    wr_slot(1, 64'h0000_0000_0010_0001);
    do_cmd("R7 commit tail dirty", 1, 0, 2);
    do_cmd("R7 fetch id2 unchanged", 2, 0, 2);
    chk_stage("R7 mask unchanged");

    // R5 flush
    do_cmd("R5 flush id0 data", 3, 0, 0);
    do_cmd("R5 fetch flushed", 2, 0, 0);
    chk_stage("R5 flushed mask zero");

    // R6 check order
    do_cmd("R6 bad id before bad at", 7, 3, 8);
    do_cmd("R6 bad at before bad op", 7, 2, 1);
    do_cmd("R6 op 0 invalid", 0, 0, 1);
    do_cmd("R6 op 4 invalid", 4, 1, 7);

    // R8 out-of-range slots and other offsets
    wr_slot(0, 64'h1111_2222_3333_4444);
    wr(12'd48, 64'hDEAD_BEEF_DEAD_BEEF);
    rd(12'd48, r); chk("R8 slot2 reads zero", r, 64'd0);
    chk_stage("R8 slot2 write ignored");
    rd(12'd33, r); chk("R8 unaligned zero", r, 64'd0);
    wr(12'd8, 64'hFFFF);
    rd(12'd8, r);  chk("R8 offset 8 zero", r, 64'd0);
    rd(12'd16, r); chk("R8 offset 16 zero", r, 64'd0);

    // R10 capabilities write ignored
    wr(12'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(12'd0, r);  chk("R10 caps unchanged", r, 64'h0000_0000_0100_5012);
    chk_stage("R10 staging untouched");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int kind;
      kind = int'($urandom % 3);
      if (kind == 0) begin
        int s;
        logic [63:0] d;
        s = int'($urandom % 3);
        d = {$urandom, $urandom};
        if (s == 1 && ($urandom % 4) != 0) d = d & 64'hFFFF;
        wr_slot(s, d);
      end else begin
        int op, at, id;
        op = int'($urandom % 5);
        at = ($urandom % 4 == 0) ? int'($urandom % 8) : int'($urandom % 2);
        id = int'($urandom % 10);
        do_cmd("R2 random command", op, at, id);
        if (op == 2) chk_stage("R4 random fetch");
      end
    end

    // sweep all entries
    for (int id = 0; id < NIDS; id++) begin
      for (int at = 0; at < 2; at++) begin
        do_cmd("R3 sweep fetch", 2, at, id);
        chk_stage("R3 sweep mask");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule